// File: doc/BRIEF.md
# Quad Output Flash Reader

This block is the host side of a read path to a serial NOR flash. A client hands it a 24-bit start address and a byte count over a request handshake. The block opens one flash transaction for the whole request and returns the bytes, in address order, on a valid/ready byte stream. Within the transaction the block sends the read command and the address one bit per clock on a single line. It then lets eight turnaround clocks pass with every pad released. After that it collects four bits per clock from all four I/O pads.

The block generates the serial clock by dividing the system clock by an even ratio. It drives an active-low select and the output enable of each pad. If the consumer stalls, the serial clock is held low at a byte boundary, so the burst goes on without being restarted. Between two requests the select stays high for a configurable minimum number of system clocks.

Top module: `qflash_quad_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, `cs_n` is 1, `sclk` is 0, `io_oe` is 4'b0000 and `dout_valid` is 0. `req_ready` is 1 once reset is released.
- R2: The first 8 rising `sclk` edges of a transaction carry the read opcode 0x6B, most significant bit first, on `io_out[0]`. During all 32 command and address edges, `io_oe` is 4'b1101: IO0 carries data, IO2 and IO3 are held high, and IO1 is released.
- R3: Rising edges 9 to 32 carry `req_addr` on `io_out[0]`, bit 23 first.
- R4: Eight dummy rising edges (33 to 40) come before the data. From the first falling edge after the last address bit until the select rises, `io_oe` is 4'b0000. While `cs_n` is high, `io_oe` is 4'b0000.
- R5: Each data byte is built from two rising edges: the first gives the high nibble and the second the low nibble, with `io_in[3]` as the MSB of each nibble. Bytes leave in the order the flash supplies them, which is at rising addresses.
- R6: A request with `req_cnt` = N-1 produces exactly 40+2N rising `sclk` edges under one select assertion, for any N up to 2^LEN_W.
- R7: `sclk` idles low (clock mode 0). It is low whenever `cs_n` is high, and the last falling edge comes before `cs_n` rises.
- R8: Each high phase of `sclk` lasts CLK_DIV/2 system clocks.
- R9: Between two transactions, `cs_n` stays high for at least CS_GAP system clocks.
- R10: While `dout_valid` is 1 and `dout_ready` is 0, `dout_valid` stays 1 and `dout_data` does not change. When the stream is stalled, the serial clock waits in its low phase before the next byte, so no byte is lost.
- R11: `req_ready` is 1 only when the block is idle. An accepted request drives `cs_n` low and `req_ready` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | 24 | Flash start address |
| req_cnt | input | LEN_W | Number of bytes minus one |
| dout_valid | output | 1 | Read byte available |
| dout_ready | input | 1 | Consumer takes the byte |
| dout_data | output | 8 | Read byte |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low flash select |
| io_out | output | 4 | Values driven onto IO3..IO0 |
| io_oe | output | 4 | Per-pad output enable, 1 = drive |
| io_in | input | 4 | Values sampled from IO3..IO0 |

## Verification
A wrong phase counter is the most likely fault, and it shows up within one transaction. The rising-edge count seen at `cs_n` deassertion is off from 40+2N. The address is shifted, or every nibble moves by one position, so the very first byte at the stream disagrees with the flash model. A bad enable register shows at the pads on the first dummy or data edge. This matters because a pad that drives during turnaround would fight the flash. A stall that loses or duplicates a byte appears as a stream mismatch only under backpressure, so those cases run with a consumer that is rarely ready.

// File: rtl/qfr_pkg.sv
package qfr_pkg;
   localparam int unsigned QFR_ADDR_W  = 24;
   localparam int unsigned QFR_HDR_W   = 8 + QFR_ADDR_W;
   localparam logic [7:0]  QFR_RD_OPC  = 8'h6B;

   typedef enum logic [2:0] {
      QS_IDLE,
      QS_HDR,
      QS_TURN,
      QS_DATA,
      QS_FLUSH,
      QS_TAIL,
      QS_GAP
   } qfr_state_t;
endpackage

// File: rtl/qfr_clkgen.sv
module qfr_clkgen #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sclk,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int unsigned HALF = CLK_DIV / 2;
   localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic tick;

   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = en;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt <= '0;
            else if (en && cnt == CW'(HALF-1)) cnt <= '0;
            else if (en)                      cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == CW'(HALF-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sclk <= 1'b0;
      else if (tick) sclk <= ~sclk;
   end

   assign rise_stb = tick && !sclk;
   assign fall_stb = tick &&  sclk;
endmodule

// File: rtl/qfr_pack.sv
module qfr_pack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       nib_stb,
   input  logic       nib_hi,
   input  logic [3:0] io_in,
   input  logic       out_ready,
   output logic       out_valid,
   output logic [7:0] out_data
);
   logic [3:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (nib_stb && nib_hi) hi_q <= io_in;
         if (nib_stb && !nib_hi) begin
            out_data  <= {hi_q, io_in};
            out_valid <= 1'b1;
         end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/qfr_seq.sv
module qfr_seq
   import qfr_pkg::*;
#(
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned CS_GAP     = 3,
   parameter int unsigned DUMMY_CLKS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [QFR_ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]      req_cnt,
   output logic                  req_ready,
   input  logic                  sclk,
   input  logic                  rise_stb,
   input  logic                  fall_stb,
   input  logic                  out_valid,
   input  logic                  out_ready,
   output logic                  clk_en,
   output logic                  cs_n,
   output logic [3:0]            io_out,
   output logic [3:0]            io_oe,
   output logic                  nib_stb,
   output logic                  nib_hi
);
   localparam int unsigned GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

   qfr_state_t             state;
   logic [QFR_HDR_W-1:0]   hdr_sh;
   logic [5:0]             edge_cnt;
   logic [LEN_W-1:0]       left;
   logic                   lo_next;
   logic [GW-1:0]          gap_cnt;
   logic                   cs_n_q;
   logic                   oe_q;
   logic                   stall;

   assign stall     = !lo_next && !sclk && out_valid && !out_ready;
   assign clk_en    = (state == QS_HDR) || (state == QS_TURN) || (state == QS_FLUSH) ||
                      ((state == QS_DATA) && !stall);
   assign req_ready = (state == QS_IDLE);
   assign nib_stb   = (state == QS_DATA) && rise_stb;
   assign nib_hi    = !lo_next;
   assign cs_n      = cs_n_q;
   assign io_out    = {2'b11, 1'b0, hdr_sh[QFR_HDR_W-1]};
   assign io_oe     = {oe_q, oe_q, 1'b0, oe_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= QS_IDLE;
         hdr_sh   <= '0;
         edge_cnt <= '0;
         left     <= '0;
         lo_next  <= 1'b0;
         gap_cnt  <= '0;
         cs_n_q   <= 1'b1;
         oe_q     <= 1'b0;
      end else begin
         unique case (state)
            QS_IDLE: if (req_valid) begin
               hdr_sh   <= {QFR_RD_OPC, req_addr};
               left     <= req_cnt;
               edge_cnt <= '0;
               lo_next  <= 1'b0;
               cs_n_q   <= 1'b0;
               oe_q     <= 1'b1;
               state    <= QS_HDR;
            end
            QS_HDR: begin
               if (fall_stb) hdr_sh <= {hdr_sh[QFR_HDR_W-2:0], 1'b0};
               if (rise_stb) begin
                  if (edge_cnt == 6'(QFR_HDR_W-1)) begin
                     edge_cnt <= '0;
                     state    <= QS_TURN;
                  end else begin
                     edge_cnt <= edge_cnt + 1'b1;
                  end
               end
            end
            QS_TURN: begin
               if (fall_stb) oe_q <= 1'b0;
               if (rise_stb) begin
                  if (edge_cnt == 6'(DUMMY_CLKS-1)) begin
                     edge_cnt <= '0;
                     state    <= QS_DATA;
                  end else begin
                     edge_cnt <= edge_cnt + 1'b1;
                  end
               end
            end
            QS_DATA: if (rise_stb) begin
               lo_next <= ~lo_next;
               if (lo_next) begin
                  if (left == '0) state <= QS_FLUSH;
                  else            left  <= left - 1'b1;
               end
            end
            QS_FLUSH: if (fall_stb) state <= QS_TAIL;
            QS_TAIL: begin
               cs_n_q  <= 1'b1;
               gap_cnt <= '0;
               state   <= QS_GAP;
            end
            QS_GAP: begin
               if (gap_cnt == GW'(CS_GAP-1)) state   <= QS_IDLE;
               else                          gap_cnt <= gap_cnt + 1'b1;
            end
            default: state <= QS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/qflash_quad_reader.sv
module qflash_quad_reader #(
   parameter int unsigned CLK_DIV    = 4,
   parameter int unsigned CS_GAP     = 3,
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned DUMMY_CLKS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [23:0]      req_addr,
   input  logic [LEN_W-1:0] req_cnt,
   output logic             dout_valid,
   input  logic             dout_ready,
   output logic [7:0]       dout_data,
   output logic             sclk,
   output logic             cs_n,
   output logic [3:0]       io_out,
   output logic [3:0]       io_oe,
   input  logic [3:0]       io_in
);
   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("CS_GAP must be at least 1");
      end
      if (DUMMY_CLKS < 1 || DUMMY_CLKS > 32) begin : g_bad_dummy
         $error("DUMMY_CLKS must lie in 1..32");
      end
      if (LEN_W < 1 || LEN_W > 24) begin : g_bad_len
         $error("LEN_W must lie in 1..24");
      end
   endgenerate

   logic clk_en, rise_stb, fall_stb, nib_stb, nib_hi;

   qfr_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (clk_en),
      .sclk     (sclk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   qfr_seq #(.LEN_W(LEN_W), .CS_GAP(CS_GAP), .DUMMY_CLKS(DUMMY_CLKS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_cnt   (req_cnt),
      .req_ready (req_ready),
      .sclk      (sclk),
      .rise_stb  (rise_stb),
      .fall_stb  (fall_stb),
      .out_valid (dout_valid),
      .out_ready (dout_ready),
      .clk_en    (clk_en),
      .cs_n      (cs_n),
      .io_out    (io_out),
      .io_oe     (io_oe),
      .nib_stb   (nib_stb),
      .nib_hi    (nib_hi)
   );

   qfr_pack u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .nib_stb   (nib_stb),
      .nib_hi    (nib_hi),
      .io_in     (io_in),
      .out_ready (dout_ready),
      .out_valid (dout_valid),
      .out_data  (dout_data)
   );
endmodule

// File: rtl/qfr_chk.sv
module qfr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       dout_valid,
   input logic       dout_ready,
   input logic [7:0] dout_data,
   input logic       sclk,
   input logic       cs_n,
   input logic [3:0] io_oe
);
   // R7
   idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R4
   idle_pads_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (io_oe == 4'b0000));

   // R10
   hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

   // R11
   accept_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!cs_n && !req_ready));

   // R9
   gap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);
endmodule

bind qflash_quad_reader qfr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .dout_valid (dout_valid),
   .dout_ready (dout_ready),
   .dout_data  (dout_data),
   .sclk       (sclk),
   .cs_n       (cs_n),
   .io_oe      (io_oe)
);

// File: tb/qflash_quad_reader_bench.sv
module qflash_quad_reader_bench;
   localparam int CLK_DIV = 4;
   localparam int CS_GAP  = 3;
   localparam int LEN_W   = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [23:0]      req_addr = '0;
   logic [LEN_W-1:0] req_cnt = '0;
   logic             dout_valid;
   logic             dout_ready = 1'b0;
   logic [7:0]       dout_data;
   logic             sclk, cs_n;
   logic [3:0]       io_out, io_oe;
   logic [3:0]       flash_drv = 4'h0;

   always #10 clk = ~clk;

   qflash_quad_reader #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .LEN_W(LEN_W)) u_qflash_quad_reader (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_cnt(req_cnt), .dout_valid(dout_valid),
      .dout_ready(dout_ready), .dout_data(dout_data), .sclk(sclk), .cs_n(cs_n),
      .io_out(io_out), .io_oe(io_oe), .io_in(flash_drv)
   );

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] fdata(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   logic [7:0]  exp_q[$];
   logic [23:0] cur_addr = '0;
   int          cur_len = 0;
   bit          txn_done = 1'b0;
   int          rdy_mode = 0;

   // flash model and protocol observer, evaluated away from the active edge
   logic        sclk_q = 1'b0, cs_q = 1'b1;
   int          rise_n = 0, hi_cnt = 0, gap_cnt = 0;
   int          oe_hdr_bad = 0, oe_dat_bad = 0, hi_bad = 0;
   logic [31:0] rx = '0;
   bit          seen_txn = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n && cs_q) begin
            if (seen_txn) chk(gap_cnt >= CS_GAP, "R9", "select high gap", gap_cnt, CS_GAP);
            rise_n = 0; rx = '0; hi_cnt = 0;
            oe_hdr_bad = 0; oe_dat_bad = 0; hi_bad = 0;
         end
         if (cs_n && !cs_q) begin
            seen_txn = 1'b1;
            gap_cnt  = 0;
            chk(sclk == 1'b0, "R7", "sclk at deselect", int'(sclk), 0);
            chk(rx[31:24] == 8'h6B, "R2", "opcode", int'(rx[31:24]), 'h6B);
            chk(oe_hdr_bad == 0, "R2", "enables in header", oe_hdr_bad, 0);
            chk(rx[23:0] == cur_addr, "R3", "address", int'(rx[23:0]), int'(cur_addr));
            chk(oe_dat_bad == 0, "R4", "enables after header", oe_dat_bad, 0);
            chk(rise_n == 40 + 2*cur_len, "R6", "rising edges", rise_n, 40 + 2*cur_len);
            chk(hi_bad == 0, "R8", "high phase length errors", hi_bad, 0);
            txn_done = 1'b1;
         end
         if (cs_n) gap_cnt++;
         if (!cs_n) begin
            if (sclk) hi_cnt++;
            if (sclk && !sclk_q) begin
               rise_n++;
               if (rise_n <= 32) begin
                  rx = {rx[30:0], io_out[0]};
                  if (io_oe != 4'b1101) oe_hdr_bad++;
               end else if (io_oe != 4'b0000) begin
                  oe_dat_bad++;
               end
            end
            if (!sclk && sclk_q) begin
               if (hi_cnt != CLK_DIV/2) hi_bad++;
               hi_cnt = 0;
               if (rise_n >= 40) begin
                  int n;
                  logic [7:0] b;
                  n = rise_n - 40;
                  b = fdata(24'(cur_addr + 24'(n/2)));
                  flash_drv = (n % 2 == 0) ? b[7:4] : b[3:0];
               end
            end
         end
         sclk_q = sclk;
         cs_q   = cs_n;
      end
   end

   // scoreboard monitor: ready is set first, then the coming handshake is judged
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            case (rdy_mode)
               0:       dout_ready = 1'b1;
               1:       dout_ready = ($urandom % 2) == 0;
               default: dout_ready = ($urandom % 5) == 0;
            endcase
            if (dout_valid && dout_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R5", "unexpected byte", int'(dout_data), 0);
               end else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  // R10 when the consumer stalls (mode 2), R5 otherwise
                  chk(dout_data == e, (rdy_mode == 2) ? "R10" : "R5", "stream byte",
                      int'(dout_data), int'(e));
               end
            end
         end
      end
   end

   task automatic do_read(input logic [23:0] a, input int n);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cur_addr = a;
      cur_len  = n;
      txn_done = 1'b0;
      for (int k = 0; k < n; k++) exp_q.push_back(fdata(24'(a + 24'(k))));
      req_valid = 1'b1;
      req_addr  = a;
      req_cnt   = LEN_W'(n - 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(cs_n == 1'b0, "R11", "select after accept", int'(cs_n), 0);
      chk(req_ready == 1'b0, "R11", "ready while busy", int'(req_ready), 0);
      while (!(txn_done && exp_q.size() == 0)) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 during reset
      chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
      chk(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
      chk(io_oe == 4'b0000, "R1", "io_oe in reset", int'(io_oe), 0);
      chk(dout_valid == 1'b0, "R1", "dout_valid in reset", int'(dout_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
      chk(cs_n == 1'b1, "R1", "cs_n after reset", int'(cs_n), 1);

      rdy_mode = 0;
      do_read(24'h000100, 1);       // single byte
      do_read(24'hABCDEF, 4);
      rdy_mode = 1;
      do_read(24'hFFFFFE, 6);       // flash address wraps
      rdy_mode = 2;
      do_read(24'h123456, 16);      // R10 heavy backpressure
      rdy_mode = 0;
      do_read(24'h00FF00, 300);     // R6 long burst under one command
      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "bytes left over", exp_q.size(), 0);
      finish_run();
   end
endmodule